// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. It stores sixteen request flags. Hardware event pulses set them and software can write them. The flags are grouped into twelve maskable sources plus one non-maskable power-fail source. A per-source enable, a global enable and a per-source high/low priority bit gate every maskable source. The power-fail source sits on a third level above both and ignores the global enable.

Arbitration runs every cycle. Among the levels that are strictly above the highest level already in service, the block picks the highest level that has a request. Inside that level it takes the earliest source in a fixed order. The winner is registered and presented as a request, a 4-bit source index and an 8-bit vector. It is held until the CPU acknowledges it. An acknowledge marks that level as in service and clears the flags that are self-clearing. A return-from-interrupt strobe retires the highest level in service, so interrupts nest correctly.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and all flags, enables, priority bits and in-service levels are 0.
- R2: Among pending sources of the same level, the earliest in this order wins: index 0 external0 (flag bit 0), 1 timer0 (bit 1), 2 external1 (bit 2), 3 timer1 (bit 3), 4 serial0 (bits 4 receive, 5 transmit), 5 timer2 (bits 6 overflow, 7 capture/reload), 6 serial1 (bits 8, 9), 7–10 external2–5 (bits 10–13), 11 watchdog (bit 14).
- R3: A pending source whose priority bit (`prio_data[index]`=1) is high wins over any pending low source, whatever their order.
- R4: While a level is in service, requests of that level or a lower one are not presented; a request of a strictly higher level is presented.
- R5: A maskable source requests only when its enable bit `en_data[index]` and the global enable `en_data[12]` are both 1.
- R6: The power-fail flag (bit 15) is presented above all other sources, even with the global enable at 0, with index 12 and vector 8'h7B.
- R7: For a maskable source, `irq_vec` equals 8 × `irq_idx` + 3.
- R8: Acknowledging timer0, timer1 or power-fail clears that flag.
- R9: Acknowledging any other source leaves its flags set, including both flags of the timer2 and serial sources.
- R10: A software write replaces all sixteen flags; a written 1 raises a request through the normal masking and arbitration.
- R11: A hardware set of a flag in the same cycle as a software write of 0 or an auto-clear leaves the flag set.
- R12: A presented request keeps its index and vector stable until acknowledged, and `irq_req` is 0 in the cycle after the acknowledge.
- R13: A return-from-interrupt strobe retires the highest in-service level only, so the next lower level is still protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_set | input | 16 | Per-flag hardware set pulses |
| sw_flag_we | input | 1 | Software flag write strobe |
| sw_flag_data | input | 16 | New value for all flags |
| en_we | input | 1 | Enable register write strobe |
| en_data | input | 13 | Per-source enables (bits 11:0) and global enable (bit 12) |
| prio_we | input | 1 | Priority register write strobe |
| prio_data | input | 12 | Per-source priority, 1 = high |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 4 | Index of the presented source |
| irq_vec | output | 8 | Vector address of the presented source |
| flag_q | output | 16 | Current flag contents for software reads |

## Verification
Two pairs of events can fall in the same cycle. A hardware flag set can coincide with a software write of zero or with the auto-clear from an acknowledge. An acknowledge can also coincide with a return-from-interrupt strobe. The directed part forces a hardware set together with a clearing write and expects the flag to read 1. The random part drives sparse hardware pulses, software writes, acknowledges and returns independently, so all of these collisions occur many times. Every cycle is judged against a reference model written from the requirements, which applies the return before the new acknowledge and lets the hardware set win.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    localparam int NUM_SRC  = 12;
    localparam int NUM_FLAG = 16;
    localparam int IDX_W    = 4;
    localparam int VEC_W    = 8;
    localparam int EN_W     = NUM_SRC + 1;
    localparam int GLB_BIT  = NUM_SRC;

    // flag bit positions
    localparam int F_EX0  = 0;
    localparam int F_TF0  = 1;
    localparam int F_EX1  = 2;
    localparam int F_TF1  = 3;
    localparam int F_RX0  = 4;
    localparam int F_TX0  = 5;
    localparam int F_OV2  = 6;
    localparam int F_CR2  = 7;
    localparam int F_RX1  = 8;
    localparam int F_TX1  = 9;
    localparam int F_EX2  = 10;
    localparam int F_EX5  = 13;
    localparam int F_WDT  = 14;
    localparam int F_PF   = 15;

    localparam logic [IDX_W-1:0] PF_IDX = IDX_W'(NUM_SRC);
    localparam logic [VEC_W-1:0] PF_VEC = 8'h7B;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic             valid;
        lvl_e             lvl;
        logic [IDX_W-1:0] idx;
        logic [VEC_W-1:0] vec;
    } grant_t;

    // flags that feed a given source index
    function automatic logic [NUM_FLAG-1:0] src_flags(input int s);
        logic [NUM_FLAG-1:0] m;
        m = '0;
        case (s)
            0: m[F_EX0] = 1'b1;
            1: m[F_TF0] = 1'b1;
            2: m[F_EX1] = 1'b1;
            3: m[F_TF1] = 1'b1;
            4: begin m[F_RX0] = 1'b1; m[F_TX0] = 1'b1; end
            5: begin m[F_OV2] = 1'b1; m[F_CR2] = 1'b1; end
            6: begin m[F_RX1] = 1'b1; m[F_TX1] = 1'b1; end
            7, 8, 9, 10: m[F_EX2 + s - 7] = 1'b1;
            11: m[F_WDT] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // flags cleared by hardware when the source is acknowledged
    function automatic logic [NUM_FLAG-1:0] autoclr_mask(input logic [IDX_W-1:0] idx);
        logic [NUM_FLAG-1:0] m;
        m = '0;
        if (idx == IDX_W'(1))  m[F_TF0] = 1'b1;
        if (idx == IDX_W'(3))  m[F_TF1] = 1'b1;
        if (idx == PF_IDX)     m[F_PF]  = 1'b1;
        return m;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        v = '0;
        v[IDX_W+2:0] = {idx, 3'b011};
        return v;
    endfunction

    // highest in-service level from the stack bits (bit0 low, bit1 high, bit2 top)
    function automatic lvl_e top_level(input logic [2:0] isv);
        if (isv[2])      return LVL_TOP;
        else if (isv[1]) return LVL_HIGH;
        else if (isv[0]) return LVL_LOW;
        return LVL_NONE;
    endfunction

endpackage

// File: rtl/nirq_flags.sv
module nirq_flags
    import nirq_pkg::*;
#(
    parameter int NF = NUM_FLAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] hw_set,
    input  logic          sw_we,
    input  logic [NF-1:0] sw_data,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags
);

    logic [NF-1:0] kept;

    always_comb begin
        if (sw_we) kept = sw_data;
        else       kept = flags & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= kept | hw_set;
    end

    // R11: a hardware set always lands, whatever software or auto-clear does
    assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/nirq_mask.sv
module nirq_mask
    import nirq_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int NF = NUM_FLAG
) (
    input  logic [NF-1:0] flags,
    input  logic [NS:0]   en,
    output logic [NS-1:0] src_req,
    output logic          pf_req
);

    for (genvar s = 0; s < NS; s++) begin : g_src
        localparam logic [NF-1:0] MASK = src_flags(s);
        assign src_req[s] = (|(flags & MASK)) & en[s] & en[NS];
    end

    assign pf_req = flags[F_PF];

endmodule

// File: rtl/nirq_arb.sv
module nirq_arb
    import nirq_pkg::*;
#(
    parameter int NS = NUM_SRC
) (
    input  logic [NS-1:0] src_req,
    input  logic [NS-1:0] prio,
    input  logic          pf_req,
    input  lvl_e          cur_lvl,
    output grant_t        grant
);

    logic [NS-1:0]    hi_pend, lo_pend;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    function automatic logic [IDX_W-1:0] first_set(input logic [NS-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NS - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    assign hi_pend = src_req & prio;
    assign lo_pend = src_req & ~prio;
    assign hi_idx  = first_set(hi_pend);
    assign lo_idx  = first_set(lo_pend);

    always_comb begin
        grant = '0;
        if (pf_req && cur_lvl < LVL_TOP) begin
            grant.valid = 1'b1;
            grant.lvl   = LVL_TOP;
            grant.idx   = PF_IDX;
            grant.vec   = PF_VEC;
        end else if ((|hi_pend) && cur_lvl < LVL_HIGH) begin
            grant.valid = 1'b1;
            grant.lvl   = LVL_HIGH;
            grant.idx   = hi_idx;
            grant.vec   = vec_of(hi_idx);
        end else if ((|lo_pend) && cur_lvl < LVL_LOW) begin
            grant.valid = 1'b1;
            grant.lvl   = LVL_LOW;
            grant.idx   = lo_idx;
            grant.vec   = vec_of(lo_idx);
        end
    end

endmodule

// File: rtl/nirq_nest.sv
module nirq_nest
    import nirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack,
    input  lvl_e ack_lvl,
    input  logic reti,
    output lvl_e cur_lvl
);

    logic [2:0] isv, after_ret, isv_next;

    always_comb begin
        after_ret = isv;
        if (reti) begin
            if (isv[2])      after_ret[2] = 1'b0;
            else if (isv[1]) after_ret[1] = 1'b0;
            else             after_ret[0] = 1'b0;
        end
        isv_next = after_ret;
        if (ack && ack_lvl != LVL_NONE)
            isv_next[ack_lvl - 2'd1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isv <= '0;
        else     isv <= isv_next;
    end

    assign cur_lvl = top_level(isv);

    // R13: a return without a new acknowledge retires exactly one level
    assert_reti_pops_one_R13: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && isv != 3'b000) |=> ($countones(isv) == $countones($past(isv)) - 1));

    // R4: an acknowledge never lowers the protected level
    assert_ack_raises_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && !reti) |=> (cur_lvl >= $past(ack_lvl)));

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FLAG-1:0] hw_set,
    input  logic                sw_flag_we,
    input  logic [NUM_FLAG-1:0] sw_flag_data,
    input  logic                en_we,
    input  logic [EN_W-1:0]     en_data,
    input  logic                prio_we,
    input  logic [NUM_SRC-1:0]  prio_data,
    input  logic                irq_ack,
    input  logic                irq_reti,
    output logic                irq_req,
    output logic [IDX_W-1:0]    irq_idx,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [NUM_FLAG-1:0] flag_q
);

    logic [EN_W-1:0]     en_q;
    logic [NUM_SRC-1:0]  prio_q;
    logic [NUM_SRC-1:0]  src_req;
    logic                pf_req;
    logic [NUM_FLAG-1:0] clr_mask;
    logic                ack_fire;
    lvl_e                cur_lvl;
    grant_t              grant, out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            prio_q <= '0;
        end else begin
            if (en_we)   en_q   <= en_data;
            if (prio_we) prio_q <= prio_data;
        end
    end

    assign ack_fire = irq_ack & out_q.valid;
    assign clr_mask = ack_fire ? autoclr_mask(out_q.idx) : '0;

    nirq_flags #(.NF(NUM_FLAG)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .sw_we    (sw_flag_we),
        .sw_data  (sw_flag_data),
        .clr_mask (clr_mask),
        .flags    (flag_q)
    );

    nirq_mask #(.NS(NUM_SRC), .NF(NUM_FLAG)) u_mask (
        .flags   (flag_q),
        .en      (en_q),
        .src_req (src_req),
        .pf_req  (pf_req)
    );

    nirq_arb #(.NS(NUM_SRC)) u_arb (
        .src_req (src_req),
        .prio    (prio_q),
        .pf_req  (pf_req),
        .cur_lvl (cur_lvl),
        .grant   (grant)
    );

    nirq_nest u_nest (
        .clk     (clk),
        .rst     (rst),
        .ack     (ack_fire),
        .ack_lvl (out_q.lvl),
        .reti    (irq_reti),
        .cur_lvl (cur_lvl)
    );

    // presented request: loaded only when idle, dropped on acknowledge
    always_ff @(posedge clk) begin
        if (rst)               out_q <= '0;
        else if (ack_fire)     out_q.valid <= 1'b0;
        else if (!out_q.valid) out_q <= grant;
    end

    assign irq_req = out_q.valid;
    assign irq_idx = out_q.idx;
    assign irq_vec = out_q.vec;

    // R12: request held steady until acknowledged
    assert_hold_until_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_idx) && $stable(irq_vec)));

    // R12: acknowledge drops the request for one cycle
    assert_drop_on_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R4: a presented request is always strictly above the in-service level
    assert_strictly_higher_R4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (out_q.lvl > cur_lvl));

    // R8: acknowledging timer0 clears its flag unless re-set or rewritten
    assert_autoclr_t0_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && irq_idx == IDX_W'(1) && !hw_set[F_TF0] && !sw_flag_we)
        |=> !flag_q[F_TF0]);

    // R6: power-fail always carries its fixed vector
    assert_pf_vector_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_idx == PF_IDX) |-> (irq_vec == PF_VEC));

endmodule

// File: tb/nested_irq_ctrl_test.sv
`timescale 1ns/1ps
module nested_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] hw_set;
    logic        sw_flag_we;
    logic [15:0] sw_flag_data;
    logic        en_we;
    logic [12:0] en_data;
    logic        prio_we;
    logic [11:0] prio_data;
    logic        irq_ack, irq_reti;
    logic        irq_req;
    logic [3:0]  irq_idx;
    logic [7:0]  irq_vec;
    logic [15:0] flag_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nested_irq_ctrl uut (
        .clk(clk), .rst(rst), .hw_set(hw_set), .sw_flag_we(sw_flag_we),
        .sw_flag_data(sw_flag_data), .en_we(en_we), .en_data(en_data),
        .prio_we(prio_we), .prio_data(prio_data), .irq_ack(irq_ack),
        .irq_reti(irq_reti), .irq_req(irq_req), .irq_idx(irq_idx),
        .irq_vec(irq_vec), .flag_q(flag_q)
    );

    // reference model state
    logic [15:0] m_flags;
    logic [12:0] m_en;
    logic [11:0] m_prio;
    logic [2:0]  m_isv;
    logic        m_req;
    int          m_idx, m_lvl;

    function automatic logic [15:0] b_src(input int s);
        case (s)
            0: return 16'h0001;
            1: return 16'h0002;
            2: return 16'h0004;
            3: return 16'h0008;
            4: return 16'h0030;
            5: return 16'h00C0;
            6: return 16'h0300;
            7: return 16'h0400;
            8: return 16'h0800;
            9: return 16'h1000;
            10: return 16'h2000;
            default: return 16'h4000;
        endcase
    endfunction

    function automatic int b_cur(input logic [2:0] isv);
        if (isv[2]) return 3;
        if (isv[1]) return 2;
        if (isv[0]) return 1;
        return 0;
    endfunction

    function automatic int b_vec(input int idx);
        return (idx == 12) ? 8'h7B : idx * 8 + 3;
    endfunction

    // expected winner: returns level (0 none), idx via output
    function automatic int b_pick(output int idx);
        int cur = b_cur(m_isv);
        idx = 0;
        if (m_flags[15] && cur < 3) begin idx = 12; return 3; end
        for (int lv = 2; lv >= 1; lv--) begin
            if (cur < lv) begin
                for (int s = 0; s < 12; s++) begin
                    if ((m_flags & b_src(s)) != 0 && m_en[s] && m_en[12] &&
                        (m_prio[s] == (lv == 2))) begin
                        idx = s; return lv;
                    end
                end
            end
        end
        return 0;
    endfunction

    task automatic model_edge();
        int     nidx, nlvl;
        logic [15:0] keep;
        logic [2:0]  isv_n;
        bit     fire;
        if (rst) begin
            m_flags = 0; m_en = 0; m_prio = 0; m_isv = 0; m_req = 0; m_idx = 0; m_lvl = 0;
            return;
        end
        nlvl = b_pick(nidx);
        fire = irq_ack && m_req;
        isv_n = m_isv;
        if (irq_reti) begin
            if (isv_n[2]) isv_n[2] = 0;
            else if (isv_n[1]) isv_n[1] = 0;
            else isv_n[0] = 0;
        end
        if (fire) isv_n[m_lvl-1] = 1;
        keep = m_flags;
        if (fire && m_idx == 1)  keep[1] = 0;
        if (fire && m_idx == 3)  keep[3] = 0;
        if (fire && m_idx == 12) keep[15] = 0;
        if (sw_flag_we) keep = sw_flag_data;
        m_flags = keep | hw_set;
        if (en_we) m_en = en_data;
        if (prio_we) m_prio = prio_data;
        m_isv = isv_n;
        if (fire) m_req = 0;
        else if (!m_req) begin
            m_req = (nlvl != 0); m_idx = nidx; m_lvl = nlvl;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk(irq_req == m_req, "R2 R3 R4 R5 irq_req vs model", irq_req, m_req);
        if (m_req && irq_req) begin
            chk(irq_idx == m_idx, "R2 R3 R6 irq_idx vs model", irq_idx, m_idx);
            chk(irq_vec == b_vec(m_idx), "R7 irq_vec vs model", irq_vec, b_vec(m_idx));
        end
        chk(flag_q == m_flags, "R8 R9 R10 R11 flags vs model", flag_q, m_flags);
    endtask

    task automatic idle_inputs();
        hw_set = 0; sw_flag_we = 0; sw_flag_data = 0; en_we = 0; en_data = 0;
        prio_we = 0; prio_data = 0; irq_ack = 0; irq_reti = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp_model();
        idle_inputs();
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        rst = 1;
        @(negedge clk);
        tick();
        tick();
        rst = 0;
        chk(irq_req == 0, "R1 req after reset", irq_req, 0);
        chk(flag_q == 0, "R1 flags after reset", flag_q, 0);

        // enable all, everything low priority
        en_we = 1; en_data = 13'h1FFF; tick();
        sw_flag_we = 1; sw_flag_data = 16'h0006; tick();
        chk(flag_q == 16'h0006, "R10 software write", flag_q, 16'h0006);
        tick();
        chk(irq_req && irq_idx == 1, "R2 timer0 before external1", irq_idx, 1);
        chk(irq_vec == 8'd11, "R7 vector of index 1", irq_vec, 11);
        tick();
        chk(irq_req && irq_idx == 1, "R12 held without ack", irq_idx, 1);
        irq_ack = 1; tick();
        chk(irq_req == 0, "R12 drop after ack", irq_req, 0);
        chk(flag_q == 16'h0004, "R8 timer0 auto-cleared", flag_q, 16'h0004);
        tick(); tick();
        chk(irq_req == 0, "R4 equal level blocked", irq_req, 0);
        prio_we = 1; prio_data = 12'h004; tick(); tick();
        chk(irq_req && irq_idx == 2, "R4 higher level nests", irq_idx, 2);
        irq_ack = 1; tick();
        chk(flag_q[2] == 1, "R9 external1 flag kept", flag_q[2], 1);
        tick();
        irq_reti = 1; tick(); tick();
        chk(irq_req && irq_idx == 2, "R13 only high retired", irq_idx, 2);
        sw_flag_we = 1; sw_flag_data = 16'h0000; tick();
        irq_ack = 1; tick();
        irq_reti = 1; tick();
        irq_reti = 1; tick();

        // R3: watchdog high beats external0 low
        prio_we = 1; prio_data = 12'h800; tick();
        sw_flag_we = 1; sw_flag_data = 16'h4001; tick(); tick();
        chk(irq_req && irq_idx == 11, "R3 high watchdog wins", irq_idx, 11);
        chk(irq_vec == 8'd91, "R7 vector of index 11", irq_vec, 91);
        irq_ack = 1; tick();
        sw_flag_we = 1; sw_flag_data = 16'h0000; tick();
        irq_reti = 1; tick(); tick();

        // R5/R6: global off blocks timer1, power-fail passes
        en_we = 1; en_data = 13'h0FFF; tick();
        sw_flag_we = 1; sw_flag_data = 16'h8038; tick(); tick();
        chk(irq_req && irq_idx == 12, "R6 power-fail index", irq_idx, 12);
        chk(irq_vec == 8'h7B, "R6 power-fail vector", irq_vec, 8'h7B);
        irq_ack = 1; tick();
        chk(flag_q == 16'h0038, "R8 R9 power-fail cleared, serial kept", flag_q, 16'h0038);
        tick(); tick();
        chk(irq_req == 0, "R5 global enable blocks", irq_req, 0);
        irq_reti = 1; tick(); tick();
        chk(irq_req == 0, "R5 global enable blocks after return", irq_req, 0);

        // R11: hardware set against software clear
        hw_set = 16'h4000; sw_flag_we = 1; sw_flag_data = 16'h0000; tick();
        chk(flag_q == 16'h4000, "R11 hardware set wins", flag_q, 16'h4000);
        sw_flag_we = 1; sw_flag_data = 16'h0000; tick();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < 16; b++)
                hw_set[b] = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 19) == 0) begin
                sw_flag_we = 1; sw_flag_data = 16'($urandom);
            end
            if ($urandom_range(0, 49) == 0) begin
                en_we = 1; en_data = 13'($urandom) | 13'h1000;
            end
            if ($urandom_range(0, 29) == 0) begin
                prio_we = 1; prio_data = 12'($urandom);
            end
            irq_ack  = ($urandom_range(0, 2) == 0);
            irq_reti = ($urandom_range(0, 7) == 0);
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule